// File: doc/BRIEF.md
# ADC Step Sequencer with Result Queue

This block runs a short, programmable list of analog-to-digital conversion steps each time it is triggered. A control word holds one 4-bit descriptor per step. Each descriptor chooses the temperature-sensor source and the differential mode for that conversion. It also says whether finishing the step raises an interrupt and whether the step ends the sequence. A single trigger therefore runs anywhere from one to four conversions.

For each step the block sends a request to an external converter over a valid/ready channel. It then takes the returned result over a second valid/ready channel and appends it to a four-entry result queue. Software or a downstream consumer drains the queue through a valid/ready read port, oldest result first.

A status word exposes the queue's read and write pointers together with its full and empty flags. Misuse of the queue is recorded in two sticky flags, one for overflow and one for underflow. The interrupt output is a raw sticky bit gated by a mask input.

Back-pressure rules:
- **Request channel.** `conv_req_valid` is held with stable step information until `conv_req_ready` is seen.
- **Result channel.** `conv_res_ready` is high only while a result is awaited, and a result is taken on the first cycle that `conv_res_valid` is high.
- **Read port.** A cycle with `rd_ready` high and `rd_valid` high pops one entry. A cycle with `rd_ready` high and `rd_valid` low is an attempted read of an empty queue.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0x100, and `busy`, `ovf_flag`, `unf_flag`, `int_raw` and `int_out` are all 0.
- R2: A write stores bits 15:0 of `ctrl_wr_data` as the control word, and bits 31:16 of `ctrl_rd_data` always read 0. Step k uses bits 4k+3..4k, where bit 3 of a nibble selects the temperature sensor, bit 2 enables the interrupt, bit 1 marks end of sequence and bit 0 selects differential mode.
- R3: A trigger while idle starts at step 0 and issues one request per step in ascending order. Each request carries the step index and that step's temperature and differential bits, held stable while `conv_req_valid` is high and `conv_req_ready` is low.
- R4: The sequence stops after the first step whose end bit is set. If no end bit is set, it stops after step 3, and `busy` falls in the cycle after the last result is accepted.
- R5: A trigger that arrives while `busy` is high is ignored; it neither restarts the sequence nor starts another one afterwards.
- R6: Every accepted result is queued, and the read port returns results in arrival order with `rd_valid` high whenever the queue is not empty.
- R7: Status bits 1:0 hold the write (tail) pointer and bits 5:4 the read (head) pointer. Bit 8 is empty, bit 12 is full, and all other bits read 0.
- R8: A result arriving while the queue is full is dropped, leaves contents and pointers unchanged, and sets `ovf_flag`. The flag stays set until an `ovf_clr` pulse; when both occur in one cycle, setting wins.
- R9: An attempted read while the queue is empty sets `unf_flag` and changes nothing else. The flag stays set until an `unf_clr` pulse.
- R10: Completing a step whose interrupt bit is set sets `int_raw`, which holds until an `int_clr` pulse. `int_out` equals `int_raw` AND `int_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr_en | input | 1 | Write strobe for the control word |
| ctrl_wr_data | input | 32 | Control word write data |
| ctrl_rd_data | output | 32 | Control word read-back |
| trig | input | 1 | Start pulse |
| busy | output | 1 | Sequence in progress |
| conv_req_valid | output | 1 | Conversion request valid |
| conv_req_ready | input | 1 | Converter accepts request |
| conv_req_step | output | 2 | Step index of the request |
| conv_req_temp | output | 1 | Temperature-sensor source select |
| conv_req_diff | output | 1 | Differential mode select |
| conv_res_valid | input | 1 | Conversion result valid |
| conv_res_ready | output | 1 | Block waits for a result |
| conv_res_data | input | 10 | Conversion result |
| rd_valid | output | 1 | Queue holds a result |
| rd_ready | input | 1 | Consumer pops / read attempt |
| rd_data | output | 10 | Oldest queued result |
| fifo_status | output | 16 | Pointers, empty and full flags |
| ovf_flag | output | 1 | Sticky overflow |
| ovf_clr | input | 1 | Clear pulse for overflow |
| unf_flag | output | 1 | Sticky underflow |
| unf_clr | input | 1 | Clear pulse for underflow |
| int_mask | input | 1 | Interrupt output enable |
| int_clr | input | 1 | Clear pulse for raw interrupt |
| int_raw | output | 1 | Sticky raw interrupt status |
| int_out | output | 1 | Masked interrupt |

## Verification
On every cycle, the in-line assertions check several local rules:
- a pending request holds its step stable;
- steps advance by exactly one;
- the block goes idle right after a final step;
- the step index cannot move while busy except on an accepted result;
- an overflowing push leaves the write pointer untouched;
- an empty-read leaves the read pointer untouched;
- all three sticky flags hold until cleared.

Only the bench's scenarios can show the end-to-end properties. These include the order and values of results across many random control words, and the exact status word encoding. They also include the fact that a trigger pulse during a run leaves no trace afterwards, and the interaction of masking with the raw interrupt.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int DESC_W = 4;

  typedef struct packed {
    logic temp;
    logic ie;
    logic last;
    logic diff;
  } step_desc_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_t;
endpackage

// File: rtl/adc_seq_ctrlreg.sv
module adc_seq_ctrlreg
  import adc_seq_pkg::*;
#(
  parameter int NUM_STEPS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [31:0]                   wr_data,
  output logic [31:0]                   rd_data,
  output step_desc_t [NUM_STEPS-1:0]    desc
);
  localparam int CW = NUM_STEPS * DESC_W;

  logic [CW-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data[CW-1:0];
  end

  assign rd_data = {{(32-CW){1'b0}}, ctrl_q};

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_desc
    assign desc[g] = step_desc_t'(ctrl_q[g*DESC_W +: DESC_W]);
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q)); // R2
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_STEPS = 4,
  parameter int RES_W     = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         trig,
  input  step_desc_t [NUM_STEPS-1:0]   desc,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [$clog2(NUM_STEPS)-1:0] req_step,
  output logic                         req_temp,
  output logic                         req_diff,
  input  logic                         res_valid,
  output logic                         res_ready,
  input  logic [RES_W-1:0]             res_data,
  output logic                         push,
  output logic [RES_W-1:0]             push_data,
  output logic                         irq_set,
  output logic                         busy
);
  localparam int STEP_W = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  sq_state_t         state_q;
  logic [STEP_W-1:0] step_q;
  step_desc_t        cur;
  logic              final_step;
  logic              res_hs;

  assign cur        = desc[step_q];
  assign final_step = cur.last || (step_q == LAST_STEP);
  assign req_valid  = (state_q == SQ_REQ);
  assign res_ready  = (state_q == SQ_WAIT);
  assign res_hs     = res_valid && res_ready;
  assign req_step   = step_q;
  assign req_temp   = cur.temp;
  assign req_diff   = cur.diff;
  assign push       = res_hs;
  assign push_data  = res_data;
  assign irq_set    = res_hs && cur.ie;
  assign busy       = (state_q != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (trig) begin
          state_q <= SQ_REQ;
          step_q  <= '0;
        end
        SQ_REQ: if (req_ready) state_q <= SQ_WAIT;
        SQ_WAIT: if (res_valid) begin
          if (final_step) state_q <= SQ_IDLE;
          else begin
            step_q  <= step_q + 1'b1;
            state_q <= SQ_REQ;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_step)); // R3
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    res_hs && !final_step |=> req_valid && (req_step == $past(req_step) + 1'b1)); // R3
  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    res_hs && final_step |=> !busy && !req_valid); // R4
  AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !res_hs |=> busy && $stable(req_step)); // R5
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DEPTH = 4,
  parameter int RES_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [RES_W-1:0]         push_data,
  input  logic                     pop_try,
  output logic                     rd_valid,
  output logic [RES_W-1:0]         rd_data,
  output logic [$clog2(DEPTH)-1:0] head,
  output logic [$clog2(DEPTH)-1:0] tail,
  output logic                     full,
  output logic                     empty,
  output logic                     ovf,
  input  logic                     ovf_clr,
  output logic                     unf,
  input  logic                     unf_clr
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W:0]   FULL_CNT = (PTR_W+1)'(DEPTH);

  logic [RES_W-1:0] mem [DEPTH];
  logic [PTR_W:0]   cnt_q;
  logic [PTR_W-1:0] head_q, tail_q;
  logic             push_ok, pop_ok;

  assign full     = (cnt_q == FULL_CNT);
  assign empty    = (cnt_q == '0);
  assign push_ok  = push && !full;
  assign pop_ok   = pop_try && !empty;
  assign rd_valid = !empty;
  assign rd_data  = mem[head_q];
  assign head     = head_q;
  assign tail     = tail_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[tail_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      if (push_ok) tail_q <= (tail_q == LAST_IDX) ? '0 : tail_q + 1'b1;
      if (pop_ok)  head_q <= (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push && full)         ovf <= 1'b1;
      else if (ovf_clr)         ovf <= 1'b0;
      if (pop_try && empty)     unf <= 1'b1;
      else if (unf_clr)         unf <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push && full |=> $stable(tail_q) && ovf); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_try && empty |=> $stable(head_q) && unf); // R9
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf && !unf_clr |=> unf); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R7
  AST_PTR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (empty || full) |-> head_q == tail_q); // R7
endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic mask,
  output logic raw,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   raw <= 1'b0;
    else if (set) raw <= 1'b1;
    else if (clr) raw <= 1'b0;
  end

  assign irq = raw && mask;

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    raw && !clr |=> raw); // R10
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> raw); // R10
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_STEPS = 4,
  parameter int DEPTH     = 4,
  parameter int RES_W     = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctrl_wr_en,
  input  logic [31:0]                  ctrl_wr_data,
  output logic [31:0]                  ctrl_rd_data,
  input  logic                         trig,
  output logic                         busy,
  output logic                         conv_req_valid,
  input  logic                         conv_req_ready,
  output logic [$clog2(NUM_STEPS)-1:0] conv_req_step,
  output logic                         conv_req_temp,
  output logic                         conv_req_diff,
  input  logic                         conv_res_valid,
  output logic                         conv_res_ready,
  input  logic [RES_W-1:0]             conv_res_data,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic [RES_W-1:0]             rd_data,
  output logic [15:0]                  fifo_status,
  output logic                         ovf_flag,
  input  logic                         ovf_clr,
  output logic                         unf_flag,
  input  logic                         unf_clr,
  input  logic                         int_mask,
  input  logic                         int_clr,
  output logic                         int_raw,
  output logic                         int_out
);
  localparam int PTR_W = $clog2(DEPTH);

  step_desc_t [NUM_STEPS-1:0] desc;
  logic                       push, irq_set, full, empty;
  logic [RES_W-1:0]           push_data;
  logic [PTR_W-1:0]           head, tail;

  adc_seq_ctrlreg #(.NUM_STEPS(NUM_STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr_en), .wr_data(ctrl_wr_data),
    .rd_data(ctrl_rd_data), .desc(desc)
  );

  adc_seq_fsm #(.NUM_STEPS(NUM_STEPS), .RES_W(RES_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trig(trig), .desc(desc),
    .req_valid(conv_req_valid), .req_ready(conv_req_ready),
    .req_step(conv_req_step), .req_temp(conv_req_temp), .req_diff(conv_req_diff),
    .res_valid(conv_res_valid), .res_ready(conv_res_ready), .res_data(conv_res_data),
    .push(push), .push_data(push_data), .irq_set(irq_set), .busy(busy)
  );

  adc_seq_fifo #(.DEPTH(DEPTH), .RES_W(RES_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop_try(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .head(head), .tail(tail), .full(full), .empty(empty),
    .ovf(ovf_flag), .ovf_clr(ovf_clr), .unf(unf_flag), .unf_clr(unf_clr)
  );

  adc_seq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(int_clr),
    .mask(int_mask), .raw(int_raw), .irq(int_out)
  );

  always_comb begin
    fifo_status         = '0;
    fifo_status[PTR_W-1:0]   = tail;
    fifo_status[4 +: PTR_W]  = head;
    fifo_status[8]      = empty;
    fifo_status[12]     = full;
  end
endmodule

// File: tb/adc_seq_top_test.sv
`timescale 1ns/1ps
module adc_seq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr_en = 1'b0;
  logic [31:0] ctrl_wr_data = '0;
  logic [31:0] ctrl_rd_data;
  logic        trig = 1'b0, busy;
  logic        conv_req_valid, conv_req_ready = 1'b0;
  logic [1:0]  conv_req_step;
  logic        conv_req_temp, conv_req_diff;
  logic        conv_res_valid = 1'b0, conv_res_ready;
  logic [9:0]  conv_res_data = '0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [9:0]  rd_data;
  logic [15:0] fifo_status;
  logic        ovf_flag, ovf_clr = 1'b0, unf_flag, unf_clr = 1'b0;
  logic        int_mask = 1'b0, int_clr = 1'b0, int_raw, int_out;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model of the queue and flags
  logic [9:0] m_mem [4];
  int         m_cnt = 0, m_head = 0, m_tail = 0;
  bit         m_ovf = 0, m_unf = 0, m_raw = 0;
  int         seq_id = 0;

  always #4 clk = ~clk;

  adc_seq_top uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int last_step(input logic [15:0] c);
    for (int k = 0; k < 4; k++) if (c[4*k+1]) return k;
    return 3;
  endfunction

  function automatic logic [15:0] exp_status();
    logic [15:0] s = '0;
    s[1:0]  = 2'(m_tail);
    s[5:4]  = 2'(m_head);
    s[8]    = (m_cnt == 0);
    s[12]   = (m_cnt == 4);
    return s;
  endfunction

  task automatic check_state(input string tag);
    chk(fifo_status == exp_status(), {tag, " R7 status"}, fifo_status, exp_status());
    chk(ovf_flag == m_ovf, {tag, " R8 ovf"}, ovf_flag, m_ovf);
    chk(unf_flag == m_unf, {tag, " R9 unf"}, unf_flag, m_unf);
    chk(int_raw == m_raw && int_out == (m_raw & int_mask), {tag, " R10 irq"},
        {int_raw, int_out}, {m_raw, m_raw & int_mask});
  endtask

  task automatic write_ctrl(input logic [31:0] v);
    ctrl_wr_data = v; ctrl_wr_en = 1'b1;
    @(negedge clk); ctrl_wr_en = 1'b0;
    chk(ctrl_rd_data == {16'h0, v[15:0]}, "R2 ctrl readback", ctrl_rd_data, {16'h0, v[15:0]});
  endtask

  task automatic run_seq(input logic [15:0] c, input bit trig_busy);
    int ls = last_step(c);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    for (int k = 0; k <= ls; k++) begin
      logic [9:0] val;
      if (trig_busy) begin
        trig = 1'b1; @(negedge clk); trig = 1'b0;
      end
      repeat ($urandom % 3) begin
        chk(conv_req_valid && conv_req_step == 2'(k), "R3 request held", conv_req_step, k);
        @(negedge clk);
      end
      chk(conv_req_valid && conv_req_step == 2'(k) && conv_req_temp == c[4*k+3]
          && conv_req_diff == c[4*k], "R3 request fields",
          {conv_req_valid, conv_req_step, conv_req_temp, conv_req_diff},
          {1'b1, 2'(k), c[4*k+3], c[4*k]});
      conv_req_ready = 1'b1; @(negedge clk); conv_req_ready = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
      val = {6'(seq_id), c[4*k+3], c[4*k], 2'(k)};
      seq_id++;
      chk(conv_res_ready, "R3 waits for result", conv_res_ready, 1);
      conv_res_valid = 1'b1; conv_res_data = val;
      @(negedge clk); conv_res_valid = 1'b0;
      if (m_cnt == 4) m_ovf = 1;
      else begin m_mem[m_tail] = val; m_tail = (m_tail + 1) % 4; m_cnt++; end
      if (c[4*k+2]) m_raw = 1;
    end
    chk(!busy && !conv_req_valid, "R4 stops after final step", busy, 0);
    @(negedge clk);
    chk(!busy && !conv_req_valid, "R5 busy trigger left no trace", conv_req_valid, 0);
    check_state("seq");
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      if (m_cnt > 0) begin
        chk(rd_valid && rd_data == m_mem[m_head], "R6 read order", rd_data, m_mem[m_head]);
        m_head = (m_head + 1) % 4; m_cnt--;
      end else begin
        chk(!rd_valid, "R6 empty valid", rd_valid, 0);
        m_unf = 1;
      end
      rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
    end
    check_state("pop");
  endtask

  task automatic clear_flags(input bit co, input bit cu, input bit ci);
    ovf_clr = co; unf_clr = cu; int_clr = ci;
    @(negedge clk);
    ovf_clr = 1'b0; unf_clr = 1'b0; int_clr = 1'b0;
    if (co) m_ovf = 0;
    if (cu) m_unf = 0;
    if (ci) m_raw = 0;
    check_state("clear");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctrl_rd_data == 0 && fifo_status == 16'h0100 && !busy && !ovf_flag && !unf_flag
        && !int_raw && !int_out, "R1 reset state", fifo_status, 16'h0100);
    // R2 upper bits ignored
    write_ctrl(32'hFFFF_5A3C);
    // R4 no end marker -> four steps, R10 masked interrupt
    int_mask = 1'b0;
    write_ctrl(32'h0000_4000);
    run_seq(16'h4000, 1'b0);
    chk(m_cnt == 4 && fifo_status[12], "R4 four steps without end", fifo_status, 16'h1000);
    // R8 overflow: queue full, another sequence drops everything
    write_ctrl(32'h0000_0002);
    run_seq(16'h0002, 1'b1);
    int_mask = 1'b1; @(negedge clk);
    check_state("mask");
    // R6 drain and R9 underflow
    pop_n(5);
    clear_flags(1, 1, 1);
    // R4 end in the middle, R5 trigger while busy
    write_ctrl(32'h0000_0E95);
    run_seq(16'h0E95, 1'b1);
    pop_n(3);
    // random phase
    for (int it = 0; it < 60; it++) begin
      logic [15:0] c = 16'($urandom);
      int_mask = 1'($urandom);
      write_ctrl({16'($urandom), c});
      run_seq(c, 1'($urandom % 4 == 0));
      pop_n($urandom % 6);
      if ($urandom % 3 == 0) clear_flags(1'($urandom), 1'($urandom), 1'($urandom));
    end
    pop_n(m_cnt);
    clear_flags(1, 1, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule